// File: doc/BRIEF.md
# Direct-Store I/O Reply Matcher

This block snoops a 32-bit address bus for reply transactions that answer a direct-store I/O access issued earlier by this processor. When a reply arrives on the first address beat, carries the reply transaction code and holds a receiver tag equal to the low four bits of the local tag register, the block claims it. It claims a reply only while an access is outstanding.

A claimed reply produces a registered one-cycle completion pulse. The same pulse exposes the reply's sender tag. When the outstanding access was a load, a data-forward pulse carrying the reply data appears in that same cycle. When the reply's error flag is set, a one-cycle error-exception pulse follows one cycle after completion, so load data is always delivered before the exception. Replies that do not match are dropped with no effect.

Address bits are numbered big-endian: bit 0 is `addr_i[31]` and bit 31 is `addr_i[0]`. The protocol fixes these positions: error flag at bit 2, sender tag at bits 3..11, receiver tag at bits 28..31.

Top module: `io_reply_matcher`

## Requirements
- R1: A reply is claimed when all of these hold in one cycle: `addr_valid_i`=1, `xfer_type_i`=REPLY_CODE (default 4'b1011), `beat_i`=0, the access is outstanding, and `addr_i[3:0]` (bits 28..31) equals `rx_tag_reg_i[3:0]`. The upper bits of `rx_tag_reg_i` play no part. After such a cycle, `done_o` is high for exactly the next cycle.
- R2: Bits 0..1 (`addr_i[31:30]`) and 12..27 (`addr_i[19:4]`) do not affect whether a reply is claimed or what is reported.
- R3: A cycle with `beat_i`=1 (the second beat) is never claimed, whatever the address contents.
- R4: When `done_o` is high, `sender_tag_o` equals bits 3..11 (`addr_i[28:20]`) of the claimed reply.
- R5: A reply that arrives while no access is outstanding is dropped, and `pending_o` stays 0. Claiming a reply clears `pending_o`, so a repeat of the same reply is dropped.
- R6: If the outstanding access was a load, `fwd_valid_o` is high in the same cycle as `done_o`, and `fwd_data_o` then equals the `reply_data_i` value presented with the reply. If the access was a store, `fwd_valid_o` stays low.
- R7: If the claimed reply has bit 2 (`addr_i[29]`) set, `err_exc_o` is high for exactly one cycle: the cycle after `done_o`.
- R8: If the claimed reply has bit 2 clear, `err_exc_o` stays low.
- R9: A reply with the wrong transaction code, or with a receiver tag that does not match, is dropped, and the access stays outstanding.
- R10: A synchronous active-high `rst` clears `pending_o`, `done_o`, `fwd_valid_o` and `err_exc_o`.
- R11: `issue_i` sets `pending_o` and records `issue_load_i`, but only when no access is outstanding. An issue made while an access is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | A direct-store access issues this cycle |
| issue_load_i | input | 1 | The issuing access is a load |
| addr_valid_i | input | 1 | Address bus holds a valid beat |
| xfer_type_i | input | 4 | Transaction code |
| beat_i | input | 1 | 0 for the first address beat, 1 for the second |
| addr_i | input | 32 | Address bus, big-endian bit numbering |
| rx_tag_reg_i | input | 8 | Local receiver-tag register (low 4 bits used) |
| reply_data_i | input | 32 | Data that accompanies the reply |
| pending_o | output | 1 | An access is outstanding |
| done_o | output | 1 | Completion pulse |
| fwd_valid_o | output | 1 | Load data forward pulse |
| fwd_data_o | output | 32 | Forwarded load data |
| sender_tag_o | output | 9 | Sender tag of the claimed reply |
| err_exc_o | output | 1 | Direct-store error exception pulse |

## Verification
The assertions check on every cycle the properties that hold locally. The exception pulse follows a completion and lasts one cycle. Forwarding never happens without completion. A second beat never yields a completion. The outstanding flag clears on a claim and holds otherwise. Reset leaves all pulses low. Only the bench scenarios can show the behaviour that depends on field contents: which tag values match, that the reserved and bus-side bits are ignored, that the sender tag and the load data are carried through unchanged, and that a stray or repeated reply leaves no trace.

// File: rtl/io_reply_pkg.sv
package io_reply_pkg;
  localparam int ADDR_W   = 32;
  localparam int SEND_W   = 9;
  localparam int RXTAG_W  = 4;

  // Big-endian bit n of the bus maps to vector index ADDR_W-1-n.
  localparam int ERR_BE      = 2;
  localparam int SEND_BE_LO  = 3;
  localparam int RXTAG_BE_LO = 28;

  localparam int ERR_IX      = ADDR_W - 1 - ERR_BE;
  localparam int SEND_IX_HI  = ADDR_W - 1 - SEND_BE_LO;
  localparam int RXTAG_IX_HI = ADDR_W - 1 - RXTAG_BE_LO;

  typedef struct packed {
    logic               err;
    logic [SEND_W-1:0]  sender;
    logic [RXTAG_W-1:0] rx_tag;
  } reply_fields_t;

  function automatic reply_fields_t split_addr(input logic [ADDR_W-1:0] a);
    reply_fields_t f;
    f.err    = a[ERR_IX];
    f.sender = a[SEND_IX_HI -: SEND_W];
    f.rx_tag = a[RXTAG_IX_HI -: RXTAG_W];
    return f;
  endfunction
endpackage

// File: rtl/reply_decode.sv
module reply_decode
  import io_reply_pkg::*;
#(
  parameter int          TYPE_W     = 4,
  parameter int          TAGREG_W   = 8,
  parameter logic [TYPE_W-1:0] REPLY_CODE = 4'b1011
) (
  input  logic                addr_valid,
  input  logic [TYPE_W-1:0]   xfer_type,
  input  logic                beat,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [TAGREG_W-1:0] rx_tag_reg,
  output logic                hit,
  output reply_fields_t       fields
);
  logic is_reply;
  logic tag_eq;

  always_comb begin
    fields   = split_addr(addr);
    is_reply = addr_valid && (xfer_type == REPLY_CODE) && !beat;
    tag_eq   = (fields.rx_tag == rx_tag_reg[RXTAG_W-1:0]);
    hit      = is_reply && tag_eq;
  end
endmodule

// File: rtl/outstanding_tracker.sv
module outstanding_tracker (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic issue_load,
  input  logic hit,
  output logic take,
  output logic pending_q,
  output logic load_q
);
  always_comb take = hit && pending_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      load_q    <= 1'b0;
    end else if (take) begin
      pending_q <= 1'b0;
    end else if (issue && !pending_q) begin
      pending_q <= 1'b1;
      load_q    <= issue_load;
    end
  end

  a_r5_claim_clears: assert property (@(posedge clk) disable iff (rst)
    take |=> !pending_q);
  a_r11_hold_pending: assert property (@(posedge clk) disable iff (rst)
    (pending_q && !take) |=> pending_q);
  a_r11_load_kept: assert property (@(posedge clk) disable iff (rst)
    (pending_q && !take) |=> $stable(load_q));
endmodule

// File: rtl/completion_seq.sv
module completion_seq
  import io_reply_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              is_load,
  input  reply_fields_t     fields,
  input  logic [DATA_W-1:0] data,
  output logic              done_q,
  output logic              fwd_q,
  output logic [DATA_W-1:0] data_q,
  output logic [SEND_W-1:0] sender_q,
  output logic              exc_q
);
  logic err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      fwd_q  <= 1'b0;
      err_q  <= 1'b0;
      exc_q  <= 1'b0;
    end else begin
      done_q <= take;
      fwd_q  <= take && is_load;
      err_q  <= take && fields.err;
      exc_q  <= done_q && err_q;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      sender_q <= fields.sender;
      if (is_load) data_q <= data;
    end
  end

  a_r7_exc_after_done: assert property (@(posedge clk) disable iff (rst)
    exc_q |-> $past(done_q));
  a_r7_exc_one_cycle: assert property (@(posedge clk) disable iff (rst)
    exc_q |=> !exc_q);
  a_r6_fwd_with_done: assert property (@(posedge clk) disable iff (rst)
    fwd_q |-> done_q);
  a_r4_tag_stable: assert property (@(posedge clk) disable iff (rst)
    (!done_q && !$past(take)) |-> $stable(sender_q));
endmodule

// File: rtl/io_reply_matcher.sv
module io_reply_matcher
  import io_reply_pkg::*;
#(
  parameter int                TYPE_W     = 4,
  parameter int                TAGREG_W   = 8,
  parameter int                DATA_W     = 32,
  parameter logic [TYPE_W-1:0] REPLY_CODE = 4'b1011
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                issue_i,
  input  logic                issue_load_i,
  input  logic                addr_valid_i,
  input  logic [TYPE_W-1:0]   xfer_type_i,
  input  logic                beat_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [TAGREG_W-1:0] rx_tag_reg_i,
  input  logic [DATA_W-1:0]   reply_data_i,
  output logic                pending_o,
  output logic                done_o,
  output logic                fwd_valid_o,
  output logic [DATA_W-1:0]   fwd_data_o,
  output logic [SEND_W-1:0]   sender_tag_o,
  output logic                err_exc_o
);
  logic          hit;
  logic          take;
  logic          load_q;
  reply_fields_t fields;

  reply_decode #(
    .TYPE_W(TYPE_W), .TAGREG_W(TAGREG_W), .REPLY_CODE(REPLY_CODE)
  ) u_decode (
    .addr_valid(addr_valid_i), .xfer_type(xfer_type_i), .beat(beat_i),
    .addr(addr_i), .rx_tag_reg(rx_tag_reg_i), .hit(hit), .fields(fields)
  );

  outstanding_tracker u_track (
    .clk(clk), .rst(rst), .issue(issue_i), .issue_load(issue_load_i),
    .hit(hit), .take(take), .pending_q(pending_o), .load_q(load_q)
  );

  completion_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .take(take), .is_load(load_q), .fields(fields),
    .data(reply_data_i), .done_q(done_o), .fwd_q(fwd_valid_o),
    .data_q(fwd_data_o), .sender_q(sender_tag_o), .exc_q(err_exc_o)
  );

  a_r3_second_beat_idle: assert property (@(posedge clk) disable iff (rst)
    (addr_valid_i && beat_i) |=> !done_o);
  a_r5_done_needs_pending: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(pending_o));
  a_r10_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!done_o && !fwd_valid_o && !err_exc_o && !pending_o));
endmodule

// File: tb/tb_io_reply_matcher.sv
module tb_io_reply_matcher;
  localparam logic [3:0] REPLY = 4'b1011;

  logic        clk = 1'b0;
  logic        rst;
  logic        issue_i, issue_load_i, addr_valid_i, beat_i;
  logic [3:0]  xfer_type_i;
  logic [31:0] addr_i, reply_data_i, fwd_data_o;
  logic [7:0]  rx_tag_reg_i;
  logic        pending_o, done_o, fwd_valid_o, err_exc_o;
  logic [8:0]  sender_tag_o;

  always #10 clk = ~clk;

  io_reply_matcher dut (
    .clk(clk), .rst(rst), .issue_i(issue_i), .issue_load_i(issue_load_i),
    .addr_valid_i(addr_valid_i), .xfer_type_i(xfer_type_i), .beat_i(beat_i),
    .addr_i(addr_i), .rx_tag_reg_i(rx_tag_reg_i), .reply_data_i(reply_data_i),
    .pending_o(pending_o), .done_o(done_o), .fwd_valid_o(fwd_valid_o),
    .fwd_data_o(fwd_data_o), .sender_tag_o(sender_tag_o), .err_exc_o(err_exc_o)
  );

  typedef struct {
    logic        fwd;
    logic [31:0] data;
    logic [8:0]  tag;
    logic        err;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  logic m_pend = 0, m_load = 0;
  logic exc_due = 0;
  logic finished = 0;

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_addr(input logic [1:0] rsv, input logic err,
      input logic [8:0] snd, input logic [15:0] bus, input logic [3:0] rx);
    return {rsv, err, snd, bus, rx};
  endfunction

  // Monitor: pops expected completions, checks exception timing.
  always @(negedge clk) begin
    if (!rst) begin
      if (exc_due || err_exc_o)
        chk(err_exc_o == exc_due, "R7/R8 exception pulse", {31'd0, err_exc_o}, {31'd0, exc_due});
      exc_due = 1'b0;
      if (done_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5/R9 unexpected completion", {23'd0, sender_tag_o}, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(sender_tag_o == e.tag, "R4 sender tag", {23'd0, sender_tag_o}, {23'd0, e.tag});
          chk(fwd_valid_o == e.fwd, "R6 forward valid", {31'd0, fwd_valid_o}, {31'd0, e.fwd});
          if (e.fwd)
            chk(fwd_data_o == e.data, "R6 forward data", fwd_data_o, e.data);
          exc_due = e.err;
        end
      end else if (fwd_valid_o) begin
        chk(1'b0, "R6 forward without completion", 32'd1, 32'd0);
      end
    end
  end

  task automatic idle_inputs;
    issue_i = 0; issue_load_i = 0; addr_valid_i = 0; beat_i = 0;
    xfer_type_i = 0; addr_i = 0; reply_data_i = 0;
  endtask

  task automatic issue(input logic ld);
    @(negedge clk);
    issue_i = 1; issue_load_i = ld;
    if (!m_pend) begin m_pend = 1; m_load = ld; end
    @(negedge clk);
    idle_inputs();
  endtask

  // Driver: one reply beat followed by a zeroed second beat.
  task automatic reply(input logic [3:0] ty, input logic bt, input logic [31:0] a,
                       input logic [31:0] d);
    exp_t e;
    @(negedge clk);
    addr_valid_i = 1; xfer_type_i = ty; beat_i = bt; addr_i = a; reply_data_i = d;
    if (ty == REPLY && !bt && m_pend && a[3:0] == rx_tag_reg_i[3:0]) begin
      e.fwd = m_load; e.data = d; e.tag = a[28:20]; e.err = a[29];
      exp_q.push_back(e);
      m_pend = 0;
    end
    @(negedge clk);
    beat_i = 1; addr_i = 0; reply_data_i = 0;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic settle;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rx_tag_reg_i = 8'h05;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10: reset state
    chk(!pending_o && !done_o && !fwd_valid_o && !err_exc_o, "R10 reset state",
        {28'd0, pending_o, done_o, fwd_valid_o, err_exc_o}, 32'd0);

    // R1 R2 R6 R8: load, no error, junk in ignored fields
    issue(1);
    chk(pending_o == 1, "R11 issue sets pending", {31'd0, pending_o}, 32'd1);
    reply(REPLY, 0, mk_addr(2'b11, 0, 9'h1A5, 16'hBEEF, 4'h5), 32'hCAFE0001);
    settle();
    chk(pending_o == 0 && exp_q.size() == 0, "R1 reply claimed", {31'd0, pending_o}, 32'd0);

    // R7: store with error -> no forward, exception after done
    issue(0);
    reply(REPLY, 0, mk_addr(2'b00, 1, 9'h003, 16'h0000, 4'h5), 32'h11111111);
    settle();
    chk(exp_q.size() == 0, "R7 store error completes", exp_q.size(), 0);

    // R7 R6: load with error -> forward then exception
    issue(1);
    reply(REPLY, 0, mk_addr(2'b01, 1, 9'h1FF, 16'h1234, 4'h5), 32'hDEADBEEF);
    settle();

    // R5: reply with nothing outstanding is dropped
    reply(REPLY, 0, mk_addr(2'b00, 0, 9'h055, 16'h0, 4'h5), 32'h2);
    settle();
    chk(pending_o == 0, "R5 stray reply dropped", {31'd0, pending_o}, 32'd0);

    // R9: mismatched tag, then wrong type; access stays outstanding
    issue(1);
    reply(REPLY, 0, mk_addr(2'b00, 0, 9'h0AA, 16'h0, 4'h6), 32'h3);
    settle();
    chk(pending_o == 1, "R9 tag mismatch keeps pending", {31'd0, pending_o}, 32'd1);
    reply(4'b0011, 0, mk_addr(2'b00, 1, 9'h0AA, 16'h0, 4'h5), 32'h4);
    settle();
    chk(pending_o == 1, "R9 wrong type keeps pending", {31'd0, pending_o}, 32'd1);

    // R3: second beat with matching contents is ignored
    reply(REPLY, 1, mk_addr(2'b00, 1, 9'h0AA, 16'h0, 4'h5), 32'h5);
    settle();
    chk(pending_o == 1, "R3 second beat ignored", {31'd0, pending_o}, 32'd1);

    // R1: upper tag-register bits do not matter
    rx_tag_reg_i = 8'hF5;
    reply(REPLY, 0, mk_addr(2'b10, 0, 9'h123, 16'hFFFF, 4'h5), 32'h600D600D);
    settle();
    chk(pending_o == 0, "R1 low tag bits only", {31'd0, pending_o}, 32'd0);

    // R5: repeated reply after completion dropped
    reply(REPLY, 0, mk_addr(2'b10, 0, 9'h123, 16'hFFFF, 4'h5), 32'h600D600D);
    settle();
    chk(exp_q.size() == 0, "R5 repeat dropped", exp_q.size(), 0);

    // R11: issue while pending ignored; store kind retained
    rx_tag_reg_i = 8'h0C;
    issue(0);
    issue(1);
    reply(REPLY, 0, mk_addr(2'b00, 0, 9'h0F0, 16'h0, 4'hC), 32'h77777777);
    settle();

    // R10: reset mid-access clears outstanding
    issue(1);
    @(negedge clk); rst = 1; m_pend = 0;
    @(negedge clk); rst = 0;
    chk(pending_o == 0, "R10 reset clears pending", {31'd0, pending_o}, 32'd0);
    reply(REPLY, 0, mk_addr(2'b00, 0, 9'h0F0, 16'h0, 4'hC), 32'h8);
    settle();
    chk(exp_q.size() == 0 && !exc_due, "R10 scoreboard drained", exp_q.size(), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule